// File: doc/BRIEF.md
# Wide Match Timer

This block is a free-running up-counter that is twice as wide as the register bus, paired with one comparator of the same width. Software reaches everything through a small map of bus-width registers. It can preload the counter half by half while the counter is stopped, and then start it with a control bit. The comparator is loaded the same way. When the running count equals the comparator value, a sticky status flag is raised. An enable bit gates that flag onto the interrupt line, and the flag is cleared by writing one to it.

For periodic events the counter is never reloaded. In auto-step mode each match adds a programmed bus-width step to the comparator, so the next event lands exactly one step later on the same free-running timeline. Because the two counter halves are separate registers, a reader that needs a consistent value re-reads the upper half after the lower one. If the two upper reads differ, a carry happened between them.

Top module: `wide_match_timer`

## Requirements
- R1: Register word offsets on `addr` are: 0 control (bit 0 run, bit 1 compare enable, bit 2 auto-step), 1 counter low half, 2 counter high half, 3 comparator low half, 4 comparator high half, 5 step, 6 interrupt enable (bit 0), 7 interrupt status (bit 0). After reset every register reads zero and `irq` is low.
- R2: While the run bit is clear and no counter half is written, the counter value does not change.
- R3: While the run bit is set, the counter advances by one every clock cycle, and the low half carries into the high half.
- R4: A write to one counter half replaces only that half on the next edge, and it takes priority over the increment in that cycle. Both halves read back their current value.
- R5: The comparator halves and the step register are written and read back independently.
- R6: When compare enable is set and the counter equals the comparator, the status flag is set at the next edge, whatever the interrupt enable holds.
- R7: In auto-step mode each match adds the zero-extended step to the comparator, with carry into its high half. The counter is not reloaded and keeps counting.
- R8: With compare enable clear no match occurs, and the comparator keeps its value even when auto-step is set.
- R9: `irq` is high exactly when both the status flag and interrupt enable bit 0 are set.
- R10: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A match in the same cycle as the clearing write wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following: the counter holds or steps by exactly one, a half write lands in its own half, and the comparator advances by the step on an auto-step match and otherwise stays put. They also check that a match sets the flag and that a clearing write without a match drops it. Only the bench scenarios can show the features that need a whole programming sequence. These are the carry across the 32-bit boundary, the exact count observed when the flag first appears, two successive periodic events spaced one step apart, the comparator carry on the step addition, and the read-back values of the register map.

// File: rtl/wmt_pkg.sv
package wmt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4,
        A_STEP   = 3'd5,
        A_IEN    = 3'd6,
        A_ISTAT  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic auto_step;
        logic cmp_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/wmt_counter.sv
module wmt_counter #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic [1:0]            wr_half_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   cnt_o
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int HALVES = 2;

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (|wr_half_i) begin
            for (int h = 0; h < HALVES; h++) begin
                if (wr_half_i[h]) begin
                    cnt_d.val[h*DATA_W +: DATA_W] = wdata_i;
                end
            end
        end else if (run_i) begin
            cnt_d.val = cnt_q.val + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q.val;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && wr_half_i == 2'b00) |=> cnt_q.val == $past(cnt_q.val)); // R2

    AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wr_half_i == 2'b00) |=> cnt_q.val == $past(cnt_q.val) + CNT_W'(1)); // R3

    AST_CNT_LO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_half_i == 2'b01) |=> cnt_q.val[DATA_W-1:0] == $past(wdata_i)); // R4

endmodule

// File: rtl/wmt_compare.sv
module wmt_compare #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  auto_i,
    input  logic [1:0]            wr_half_i,
    input  logic                  wr_step_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [2*DATA_W-1:0]   cnt_i,
    output logic [2*DATA_W-1:0]   cmp_o,
    output logic [DATA_W-1:0]     step_o,
    output logic                  match_o
);
    localparam int CMP_W  = 2 * DATA_W;
    localparam int HALVES = 2;

    typedef struct packed {
        logic [CMP_W-1:0]  cmp;
        logic [DATA_W-1:0] step;
    } cmp_state_t;

    cmp_state_t cs_d, cs_q;
    logic       hit;

    assign hit = en_i && (cnt_i == cs_q.cmp);

    always_comb begin
        cs_d = cs_q;
        if (wr_step_i) begin
            cs_d.step = wdata_i;
        end
        if (|wr_half_i) begin
            for (int h = 0; h < HALVES; h++) begin
                if (wr_half_i[h]) begin
                    cs_d.cmp[h*DATA_W +: DATA_W] = wdata_i;
                end
            end
        end else if (hit && auto_i) begin
            cs_d.cmp = cs_q.cmp + CMP_W'(cs_q.step);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cmp_o   = cs_q.cmp;
    assign step_o  = cs_q.step;
    assign match_o = hit;

    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && auto_i && wr_half_i == 2'b00)
        |=> cs_q.cmp == $past(cs_q.cmp) + CMP_W'($past(cs_q.step))); // R7

    AST_CMP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_o && wr_half_i == 2'b00) |=> $stable(cs_q.cmp)); // R8

endmodule

// File: rtl/wmt_irq.sv
module wmt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en_reg_i,
    input  logic en_bit_i,
    input  logic clr_i,
    output logic en_o,
    output logic stat_o,
    output logic irq_o
);
    typedef struct packed {
        logic en;
        logic stat;
    } irq_state_t;

    irq_state_t is_d, is_q;

    always_comb begin
        is_d = is_q;
        if (wr_en_reg_i) begin
            is_d.en = en_bit_i;
        end
        if (set_i) begin
            is_d.stat = 1'b1;
        end else if (clr_i) begin
            is_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_q <= '0;
        end else begin
            is_q <= is_d;
        end
    end

    assign en_o   = is_q.en;
    assign stat_o = is_q.stat;
    assign irq_o  = is_q.stat & is_q.en;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> stat_o); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !stat_o); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o); // R10

endmodule

// File: rtl/wide_match_timer.sv
module wide_match_timer #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [wmt_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       irq
);
    import wmt_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t  ts_d, ts_q;
    reg_addr_e   ra;
    logic [1:0]  wr_cnt_half;
    logic [1:0]  wr_cmp_half;
    logic        wr_step;
    logic        wr_ien;
    logic        wr_istat;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [DATA_W-1:0] step;
    logic        match;
    logic        ien;
    logic        istat;

    assign ra = reg_addr_e'(addr);

    always_comb begin
        wr_cnt_half = 2'b00;
        wr_cmp_half = 2'b00;
        wr_step     = 1'b0;
        wr_ien      = 1'b0;
        wr_istat    = 1'b0;
        if (wr_en) begin
            unique case (ra)
                A_CNT_LO: wr_cnt_half = 2'b01;
                A_CNT_HI: wr_cnt_half = 2'b10;
                A_CMP_LO: wr_cmp_half = 2'b01;
                A_CMP_HI: wr_cmp_half = 2'b10;
                A_STEP:   wr_step     = 1'b1;
                A_IEN:    wr_ien      = 1'b1;
                A_ISTAT:  wr_istat    = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        ts_d = ts_q;
        if (wr_en && ra == A_CTRL) begin
            ts_d.ctrl = ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    wmt_counter #(.DATA_W(DATA_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ts_q.ctrl.run),
        .wr_half_i (wr_cnt_half),
        .wdata_i   (wdata),
        .cnt_o     (cnt)
    );

    wmt_compare #(.DATA_W(DATA_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ts_q.ctrl.cmp_en),
        .auto_i    (ts_q.ctrl.auto_step),
        .wr_half_i (wr_cmp_half),
        .wr_step_i (wr_step),
        .wdata_i   (wdata),
        .cnt_i     (cnt),
        .cmp_o     (cmp),
        .step_o    (step),
        .match_o   (match)
    );

    wmt_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (match),
        .wr_en_reg_i (wr_ien),
        .en_bit_i    (wdata[0]),
        .clr_i       (wr_istat && wdata[0]),
        .en_o        (ien),
        .stat_o      (istat),
        .irq_o       (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (ra)
            A_CTRL:   rdata = DATA_W'(ts_q.ctrl);
            A_CNT_LO: rdata = cnt[DATA_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
            A_CMP_LO: rdata = cmp[DATA_W-1:0];
            A_CMP_HI: rdata = cmp[CNT_W-1:DATA_W];
            A_STEP:   rdata = step;
            A_IEN:    rdata = DATA_W'(ien);
            A_ISTAT:  rdata = DATA_W'(istat);
            default:  rdata = '0;
        endcase
    end

    AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_q.ctrl.cmp_en |-> !match); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && !wr_ien) |=> !irq); // R9

endmodule

// File: tb/wide_match_timer_test.sv
`timescale 1ns/1ps
module wide_match_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [2:0] R_CTRL = 3'd0, R_CLO = 3'd1, R_CHI = 3'd2, R_MLO = 3'd3,
                           R_MHI = 3'd4, R_STEP = 3'd5, R_IEN = 3'd6, R_STAT = 3'd7;

    always #2 clk = ~clk;

    wide_match_timer #(.DATA_W(32)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, tag, 64'(v), 64'(exp));
    endtask

    task automatic quiesce();
        wr(R_CTRL, 32'h0);
        wr(R_STAT, 32'h1);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) expect_reg(3'(a), 32'h0, "R1 reset value");
        check(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);
    endtask

    task automatic t_hold();
        wr(R_CLO, 32'h10);
        wr(R_CHI, 32'h2);
        repeat (5) @(negedge clk);
        expect_reg(R_CLO, 32'h10, "R2 low half held");
        expect_reg(R_CHI, 32'h2, "R4 high half read back");
    endtask

    task automatic t_carry();
        wr(R_CLO, 32'hFFFF_FFFE);
        wr(R_CHI, 32'h0);
        wr(R_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        wr(R_CTRL, 32'h0);
        expect_reg(R_CLO, 32'h2, "R3 low half after carry");
        expect_reg(R_CHI, 32'h1, "R3 carry into high half");
    endtask

    task automatic t_write_running();
        wr(R_CLO, 32'h0);
        wr(R_CHI, 32'h0);
        wr(R_CTRL, 32'h1);
        wr(R_CLO, 32'h500);
        wr(R_CTRL, 32'h0);
        expect_reg(R_CLO, 32'h501, "R4 write beats increment");
        expect_reg(R_CHI, 32'h0, "R4 other half untouched");
    endtask

    task automatic t_cmp_rw();
        wr(R_MLO, 32'hA5A5_0001);
        wr(R_MHI, 32'h0000_00C3);
        wr(R_STEP, 32'h1234_5678);
        expect_reg(R_MLO, 32'hA5A5_0001, "R5 comparator low");
        expect_reg(R_MHI, 32'h0000_00C3, "R5 comparator high");
        expect_reg(R_STEP, 32'h1234_5678, "R5 step");
    endtask

    task automatic t_match_irq();
        logic [31:0] v;
        bit seen = 0;
        wr(R_IEN, 32'h0);
        wr(R_CLO, 32'd1000);
        wr(R_CHI, 32'h0);
        wr(R_MLO, 32'd1005);
        wr(R_MHI, 32'h0);
        wr(R_CTRL, 32'h3);
        for (int i = 0; i < 50; i++) begin
            rd(R_STAT, v);
            if (v[0]) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, "R6 flag raised on match", 64'(seen), 64'h1);
        expect_reg(R_CLO, 32'd1006, "R6 flag appears one edge after match");
        check(irq == 1'b0, "R9 irq masked while enable clear", 64'(irq), 64'h0);
        wr(R_CTRL, 32'h0);
        wr(R_IEN, 32'h1);
        check(irq == 1'b1, "R9 irq once enabled", 64'(irq), 64'h1);
        wr(R_STAT, 32'h0);
        expect_reg(R_STAT, 32'h1, "R10 writing zero keeps flag");
        wr(R_STAT, 32'h1);
        expect_reg(R_STAT, 32'h0, "R10 writing one clears flag");
        check(irq == 1'b0, "R9 irq drops with flag", 64'(irq), 64'h0);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        bit seen;
        quiesce();
        wr(R_CLO, 32'd100);
        wr(R_CHI, 32'h0);
        wr(R_MLO, 32'd105);
        wr(R_MHI, 32'h0);
        wr(R_STEP, 32'd10);
        wr(R_IEN, 32'h1);
        wr(R_CTRL, 32'h7);
        for (int ev = 0; ev < 2; ev++) begin
            seen = 0;
            for (int i = 0; i < 50; i++) begin
                if (irq) begin seen = 1; break; end
                @(negedge clk);
            end
            check(seen, "R7 periodic event", 64'(seen), 64'h1);
            rd(R_CLO, v);
            check(v == 32'(106 + 10 * ev), "R7 counter not reloaded", 64'(v), 64'(106 + 10 * ev));
            rd(R_MLO, v);
            check(v == 32'(115 + 10 * ev), "R7 comparator advanced by step", 64'(v), 64'(115 + 10 * ev));
            wr(R_STAT, 32'h1);
        end
        quiesce();
    endtask

    task automatic t_step_carry();
        quiesce();
        wr(R_CLO, 32'hFFFF_FFF0);
        wr(R_CHI, 32'h0);
        wr(R_MLO, 32'hFFFF_FFF0);
        wr(R_MHI, 32'h0);
        wr(R_STEP, 32'h20);
        wr(R_CTRL, 32'h6);
        repeat (3) @(negedge clk);
        expect_reg(R_MHI, 32'h1, "R7 step carries into comparator high");
        expect_reg(R_MLO, 32'h10, "R7 comparator low after carry");
        expect_reg(R_STAT, 32'h1, "R6 match with stopped counter");
        expect_reg(R_CLO, 32'hFFFF_FFF0, "R2 stopped counter unchanged");
    endtask

    task automatic t_disabled();
        quiesce();
        wr(R_MLO, 32'h40);
        wr(R_MHI, 32'h0);
        wr(R_CLO, 32'h40);
        wr(R_CHI, 32'h0);
        wr(R_CTRL, 32'h4);
        repeat (4) @(negedge clk);
        expect_reg(R_STAT, 32'h0, "R8 no match when disabled");
        expect_reg(R_MLO, 32'h40, "R8 comparator kept when disabled");
    endtask

    task automatic t_set_beats_clear();
        wr(R_CTRL, 32'h2);
        repeat (2) @(negedge clk);
        wr(R_STAT, 32'h1);
        expect_reg(R_STAT, 32'h1, "R10 match wins over clear");
        quiesce();
        expect_reg(R_STAT, 32'h0, "R10 clear after match stops");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_carry();
        t_write_running();
        t_cmp_rw();
        t_match_irq();
        t_auto();
        t_step_carry();
        t_disabled();
        t_set_beats_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule